// File: doc/BRIEF.md
# IDE Programmed-I/O Cycle Sequencer

This block sits on the host side of a parallel storage link that runs in True IDE mode. It takes one register access at a time from a valid/ready request port and turns it into a single programmed-I/O bus cycle. Each request names a register class, a direction, a register index and write data. From these the block derives the two active-low chip selects and the 3-bit register address, then moves the read or write strobe through three phases: address setup, strobe pulse and hold.

Every timing minimum is a nanosecond parameter. At elaboration it is turned into a whole number of clock cycles by rounding up. The device can stretch the strobe pulse by holding its ready line low. A read returns the data sampled on the strobe's final low cycle. Every request ends with a one-cycle completion pulse. A request that would select both chip selects together, or that points the task-file class at index 0, finishes at once with an error flag and causes no bus activity.

Top module: `ide_pio_seq`

## Requirements
- R1: Register class 0 (16-bit data port) drives ide_cs0_n low, ide_cs1_n high and ide_addr 0, whatever the requested index. All 16 bits move: write data appears on ide_d_out[15:0], and resp_rdata returns ide_d_in[15:0].
- R2: Register class 1 (task file) with an index from 1 to 7 drives ide_cs0_n low, ide_cs1_n high and ide_addr equal to the index. Only the low byte is used: ide_d_out[15:8] is 0 on writes, and resp_rdata[15:8] is 0 on reads.
- R3: Register class 2 (device control on writes, alternate status on reads) drives ide_cs1_n low, ide_cs0_n high and ide_addr 6, with the same low-byte-only rule as R2.
- R4: After reset, and whenever req_ready is high, both chip selects and both strobes are high, ide_d_oe is 0 and resp_done is 0.
- R5: The chip selects and the address are asserted for exactly ceil(ADDR_SETUP_NS/CLK_PERIOD_NS) cycles before the strobe falls, and they do not change while the strobe is low.
- R6: The strobe stays low for at least max(ceil(STROBE_MIN_NS/T), ceil(DATA_VALID_NS/T)) cycles, where T is the clock period. With ide_iordy high throughout, it stays low for exactly that many cycles.
- R7: After the strobe rises, the chip selects and the address stay unchanged for exactly ceil(HOLD_NS/T) cycles. Then both chip selects return high.
- R8: The strobe rises only at a clock edge where ide_iordy is sampled high. If ide_iordy is first high at the edge ending low cycle N, the low time is max(N, minimum).
- R9: On a read, resp_rdata holds the ide_d_in value present during the last low cycle of ide_rd_n. resp_done pulses for exactly one cycle, in the cycle after the hold phase ends.
- R10: On a write, only ide_wr_n pulses. ide_d_oe is high from the cycle the strobe falls through the end of the hold phase, and is low at all other times. ide_d_oe is never high while ide_rd_n is low.
- R11: Register class 3, or class 1 with index 0, is rejected. resp_done and resp_err pulse in the cycle after acceptance, and neither chip select nor either strobe is asserted.
- R12: req_ready is high only when the block is idle and not pulsing resp_done. A request is accepted on a clock edge where req_valid and req_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register class: 0 data, 1 task file, 2 control/alt-status, 3 invalid |
| req_addr | input | 3 | Task-file register index |
| req_wdata | input | 16 | Write data |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Request was rejected (valid with resp_done) |
| resp_rdata | output | 16 | Read data (valid with resp_done) |
| ide_cs0_n | output | 1 | Primary chip select, active low |
| ide_cs1_n | output | 1 | Secondary chip select, active low |
| ide_addr | output | 3 | Register address |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_iordy | input | 1 | Device ready; low stretches the strobe |
| ide_d_in | input | 16 | Data bus, device to host |
| ide_d_out | output | 16 | Data bus, host to device |
| ide_d_oe | output | 1 | Host drives the data bus when high |

## Verification
Each register class is run in both directions, so a wrong chip-select pair, a forced address or a missing byte mask shows up as a decode or data mismatch. The device model puts a different value on ide_d_in in every low cycle of the strobe. A capture taken one cycle early or late therefore returns a distinguishable word. Ready-delay lengths of zero, exactly the minimum, one past it and well past it separate a strobe that ignores ide_iordy from one that adds stray cycles. Rejected selections and random mixes of all of these show whether a bad request leaks onto the bus or disturbs the next cycle.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_TASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_BOTH = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic       ok;
    logic       wide;
    logic       cs0_n;
    logic       cs1_n;
    logic [2:0] addr;
  } bus_sel_t;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/ide_pio_decode.sv
module ide_pio_decode
  import ide_pio_pkg::*;
#(
  parameter logic [2:0] CTRL_ADDR = 3'h6
) (
  input  logic [1:0] sel,
  input  logic [2:0] idx,
  output bus_sel_t   dec
);

  always_comb begin
    dec       = '0;
    dec.cs0_n = 1'b1;
    dec.cs1_n = 1'b1;
    unique case (reg_sel_e'(sel))
      SEL_DATA: begin
        dec.ok    = 1'b1;
        dec.wide  = 1'b1;
        dec.cs0_n = 1'b0;
        dec.addr  = 3'd0;
      end
      SEL_TASK: begin
        dec.ok    = (idx != 3'd0);
        dec.cs0_n = ~(idx != 3'd0);
        dec.addr  = idx;
      end
      SEL_CTRL: begin
        dec.ok    = 1'b1;
        dec.cs1_n = 1'b0;
        dec.addr  = CTRL_ADDR;
      end
      default: begin
        dec.ok = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/ide_pio_datapath.sv
module ide_pio_datapath #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_wide,
  input  logic [DW-1:0] wdata,
  input  logic          oe_set,
  input  logic          oe_clr,
  input  logic          capture,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          oe,
  output logic [DW-1:0] rdata
);

  localparam int unsigned BW = DW / 2;

  logic wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q <= 1'b0;
      d_out  <= '0;
    end else if (load) begin
      wide_q <= load_wide;
      d_out  <= load_wide ? wdata : {{(DW-BW){1'b0}}, wdata[BW-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe <= 1'b0;
    end else if (oe_clr) begin
      oe <= 1'b0;
    end else if (oe_set) begin
      oe <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= wide_q ? d_in : {{(DW-BW){1'b0}}, d_in[BW-1:0]};
    end
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned ADDR_SETUP_NS = 70,
  parameter int unsigned STROBE_MIN_NS = 165,
  parameter int unsigned HOLD_NS       = 20,
  parameter int unsigned DATA_VALID_NS = 100,
  parameter int unsigned DW            = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_sel,
  input  logic [2:0]    req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_done,
  output logic          resp_err,
  output logic [DW-1:0] resp_rdata,
  output logic          ide_cs0_n,
  output logic          ide_cs1_n,
  output logic [2:0]    ide_addr,
  output logic          ide_rd_n,
  output logic          ide_wr_n,
  input  logic          ide_iordy,
  input  logic [DW-1:0] ide_d_in,
  output logic [DW-1:0] ide_d_out,
  output logic          ide_d_oe
);

  localparam int unsigned SETUP_CYC  = ns_to_cyc(ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned PW_CYC     = ns_to_cyc(STROBE_MIN_NS, CLK_PERIOD_NS);
  localparam int unsigned DV_CYC     = ns_to_cyc(DATA_VALID_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC   = ns_to_cyc(HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned STROBE_CYC = (PW_CYC > DV_CYC) ? PW_CYC : DV_CYC;
  localparam int unsigned MAX_A      = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int unsigned CW         = $clog2(MAX_CYC + 1);

  seq_state_e state;
  bus_sel_t   dec;
  logic       tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;
  logic       write_q, done_q, err_q;
  logic       accept, accept_ok, leave_setup, leave_strobe, leave_hold;

  ide_pio_decode u_decode (
    .sel (req_sel),
    .idx (req_addr),
    .dec (dec)
  );

  assign req_ready    = (state == ST_IDLE) && !done_q;
  assign accept       = req_valid && req_ready;
  assign accept_ok    = accept && dec.ok;
  assign leave_setup  = (state == ST_SETUP)  && tmr_zero;
  assign leave_strobe = (state == ST_STROBE) && tmr_zero && ide_iordy;
  assign leave_hold   = (state == ST_HOLD)   && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept_ok) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(SETUP_CYC - 1);
    end else if (leave_setup) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(STROBE_CYC - 1);
    end else if (leave_strobe) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(HOLD_CYC - 1);
    end
  end

  ide_pio_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ide_pio_datapath #(.DW(DW)) u_data (
    .clk       (clk),
    .rst       (rst),
    .load      (accept_ok),
    .load_wide (dec.wide),
    .wdata     (req_wdata),
    .oe_set    (leave_setup && write_q),
    .oe_clr    (leave_hold),
    .capture   (leave_strobe && !write_q),
    .d_in      (ide_d_in),
    .d_out     (ide_d_out),
    .oe        (ide_d_oe),
    .rdata     (resp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ide_cs0_n <= 1'b1;
      ide_cs1_n <= 1'b1;
      ide_addr  <= '0;
      ide_rd_n  <= 1'b1;
      ide_wr_n  <= 1'b1;
      write_q   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept_ok) begin
            ide_cs0_n <= dec.cs0_n;
            ide_cs1_n <= dec.cs1_n;
            ide_addr  <= dec.addr;
            write_q   <= req_write;
            state     <= ST_SETUP;
          end else if (accept) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (leave_setup) begin
            if (write_q) ide_wr_n <= 1'b0;
            else         ide_rd_n <= 1'b0;
            state <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (leave_strobe) begin
            ide_rd_n <= 1'b1;
            ide_wr_n <= 1'b1;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (leave_hold) begin
            ide_cs0_n <= 1'b1;
            ide_cs1_n <= 1'b1;
            done_q    <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign resp_done = done_q;
  assign resp_err  = err_q;

  // Length of the current strobe-low run, for the pulse-width check.
  logic [CW+3:0] low_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
    end else if (!ide_rd_n || !ide_wr_n) begin
      if (low_run != '1) low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
    end
  end

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!ide_cs0_n && !ide_cs1_n)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ide_cs0_n && ide_cs1_n && ide_rd_n && ide_wr_n && !ide_d_oe)); // R4
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!ide_rd_n || !ide_wr_n) |-> (!ide_cs0_n || !ide_cs1_n)); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ide_rd_n || !ide_wr_n) |-> ($stable(ide_addr) && $stable(ide_cs0_n) && $stable(ide_cs1_n))); // R5
  AST_MIN_PULSE: assert property (@(posedge clk) disable iff (rst)
    ($rose(ide_rd_n) || $rose(ide_wr_n)) |-> (low_run >= (CW+4)'(STROBE_CYC))); // R6
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
    ($rose(ide_rd_n) || $rose(ide_wr_n)) |-> ((!ide_cs0_n || !ide_cs1_n) && $stable(ide_addr))); // R7
  AST_WAIT_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    ($rose(ide_rd_n) || $rose(ide_wr_n)) |-> $past(ide_iordy)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_done |=> !resp_done); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!ide_rd_n && !ide_wr_n)); // R10
  AST_OE_NOT_ON_READ: assert property (@(posedge clk) disable iff (rst)
    ide_d_oe |-> ide_rd_n); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> resp_done); // R11

endmodule

// File: tb/ide_pio_seq_tb.sv
module ide_pio_seq_tb_top;

  localparam int unsigned PERIOD = 20;

  function automatic int unsigned cyc_of(input int unsigned ns);
    int unsigned c;
    c = (ns + PERIOD - 1) / PERIOD;
    return (c == 0) ? 1 : c;
  endfunction

  localparam int unsigned E_SETUP = cyc_of(70);
  localparam int unsigned E_PW    = (cyc_of(165) > cyc_of(100)) ? cyc_of(165) : cyc_of(100);
  localparam int unsigned E_HOLD  = cyc_of(20);

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_sel;
  logic [2:0]  req_addr;
  logic [15:0] req_wdata;
  logic        resp_done, resp_err;
  logic [15:0] resp_rdata;
  logic        ide_cs0_n, ide_cs1_n, ide_rd_n, ide_wr_n, ide_iordy, ide_d_oe;
  logic [2:0]  ide_addr;
  logic [15:0] ide_d_in, ide_d_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ide_pio_seq dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sel(req_sel), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n), .ide_addr(ide_addr),
    .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n), .ide_iordy(ide_iordy),
    .ide_d_in(ide_d_in), .ide_d_out(ide_d_out), .ide_d_oe(ide_d_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected decode: {ok, cs0_n, cs1_n, addr}
  function automatic logic [5:0] exp_dec(input logic [1:0] sel, input logic [2:0] a);
    case (sel)
      2'd0:    return {1'b1, 1'b0, 1'b1, 3'd0};
      2'd1:    return (a != 3'd0) ? {1'b1, 1'b0, 1'b1, a} : {1'b0, 1'b1, 1'b1, 3'd0};
      2'd2:    return {1'b1, 1'b1, 1'b0, 3'd6};
      default: return {1'b0, 1'b1, 1'b1, 3'd0};
    endcase
  endfunction

  function automatic logic [15:0] exp_mask(input logic [1:0] sel, input logic [15:0] v);
    return (sel == 2'd0) ? v : {8'h00, v[7:0]};
  endfunction

  task automatic run_txn(input bit wr, input logic [1:0] sel, input logic [2:0] a,
                         input logic [15:0] wd, input int wlen);
    logic [5:0]  ed;
    logic [15:0] base;
    int setup_n, low_n, hold_n, cyc;
    bit seen_done, dec_bad, strobe_bad, oe_bad, dout_bad, ready_bad;
    string dtag;
    ed = exp_dec(sel, a);
    base = 16'($urandom);
    setup_n = 0; low_n = 0; hold_n = 0; cyc = 0;
    seen_done = 0; dec_bad = 0; strobe_bad = 0; oe_bad = 0; dout_bad = 0; ready_bad = 0;
    dtag = (sel == 2'd0) ? "R1" : (sel == 2'd1) ? "R2" : "R3";

    @(negedge clk);
    chk(req_ready, "R12 ready before request", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_addr = a; req_wdata = wd;
    ide_iordy = (wlen == 0);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 16'($urandom);
    while (!seen_done && cyc < 300) begin
      if (resp_done) begin
        seen_done = 1;
      end else begin
        if (req_ready) ready_bad = 1;
        if (!ide_cs0_n || !ide_cs1_n) begin
          if ({ide_cs0_n, ide_cs1_n, ide_addr} != ed[4:0]) dec_bad = 1;
          if (!ide_rd_n || !ide_wr_n) begin
            low_n++;
            if (wr ? (ide_wr_n || !ide_rd_n) : (ide_rd_n || !ide_wr_n)) strobe_bad = 1;
            if (ide_d_oe != wr) oe_bad = 1;
            if (wr && ide_d_out != exp_mask(sel, wd)) dout_bad = 1;
            ide_d_in  = base + 16'(low_n);
            ide_iordy = (low_n >= wlen);
          end else if (low_n == 0) begin
            setup_n++;
            if (ide_d_oe) oe_bad = 1;
          end else begin
            hold_n++;
            if (ide_d_oe != wr) oe_bad = 1;
          end
        end else begin
          dec_bad = 1;
        end
        @(negedge clk);
        cyc++;
      end
    end
    ide_iordy = 1'b1;

    chk(seen_done, "R9 done seen", {31'd0, seen_done}, 1);
    if (ed[5]) begin
      int exp_low;
      exp_low = (wlen > int'(E_PW)) ? wlen : int'(E_PW);
      chk(!resp_err, "R11 no error on valid select", {31'd0, resp_err}, 0);
      chk(!dec_bad, {dtag, " chip select/address decode"}, {29'd0, ide_addr}, {29'd0, ed[2:0]});
      chk(setup_n == int'(E_SETUP), "R5 setup cycles", setup_n, E_SETUP);
      chk(low_n == exp_low, (wlen > 0) ? "R8 strobe low with wait" : "R6 strobe low cycles",
          low_n, exp_low);
      chk(hold_n == int'(E_HOLD), "R7 hold cycles", hold_n, E_HOLD);
      chk(!strobe_bad, wr ? "R10 write strobe only" : "R9 read strobe only", strobe_bad, 0);
      chk(!oe_bad, "R10 output enable window", oe_bad, 0);
      if (wr)
        chk(!dout_bad, {dtag, " write data on bus"}, {31'd0, dout_bad}, 0);
      else
        chk(resp_rdata == exp_mask(sel, base + 16'(exp_low)), {dtag, " R9 read capture"},
            resp_rdata, exp_mask(sel, base + 16'(exp_low)));
    end else begin
      chk(resp_err && cyc == 0, "R11 immediate reject", {resp_err, 31'(cyc)}, 32'h8000_0000);
      chk(low_n == 0 && setup_n == 0 && !dec_bad, "R11 no bus activity", low_n + setup_n, 0);
    end
    chk(!ready_bad, "R12 ready low while busy", ready_bad, 0);
    chk(ide_cs0_n && ide_cs1_n && !ide_d_oe, "R4 bus released at done",
        {ide_cs0_n, ide_cs1_n, ide_d_oe}, 3'b110);
    @(negedge clk);
    chk(!resp_done, "R9 done is one cycle", {31'd0, resp_done}, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d3a5));
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_sel = 2'd0; req_addr = 3'd0;
    req_wdata = '0; ide_iordy = 1'b1; ide_d_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !resp_done, "R4 reset handshake", {req_ready, resp_done}, 2'b10);
    chk(ide_cs0_n && ide_cs1_n && ide_rd_n && ide_wr_n && !ide_d_oe, "R4 reset bus idle",
        {ide_cs0_n, ide_cs1_n, ide_rd_n, ide_wr_n, ide_d_oe}, 5'b11110);

    // Directed cases
    run_txn(0, 2'd0, 3'd5, 16'h0000, 0);            // R1 data read, index ignored
    run_txn(1, 2'd0, 3'd0, 16'hA55A, 0);            // R1 data write
    run_txn(0, 2'd1, 3'd7, 16'h0000, 0);            // R2 task read top index
    run_txn(1, 2'd1, 3'd1, 16'hBEEF, 0);            // R2 task write lowest index
    run_txn(1, 2'd2, 3'd3, 16'h1234, 0);            // R3 control write
    run_txn(0, 2'd2, 3'd0, 16'h0000, 0);            // R3 alt status read
    run_txn(0, 2'd0, 3'd0, 16'h0000, int'(E_PW));   // R8 wait ends exactly at minimum
    run_txn(0, 2'd1, 3'd2, 16'h0000, int'(E_PW) + 1); // R8 one past minimum
    run_txn(1, 2'd0, 3'd0, 16'h7E81, 20);           // R8 long wait on write
    run_txn(0, 2'd3, 3'd6, 16'h0000, 0);            // R11 both selects
    run_txn(1, 2'd1, 3'd0, 16'hFFFF, 0);            // R11 task index 0
    run_txn(0, 2'd0, 3'd0, 16'h0000, 0);            // follow-up after reject

    // Random mix
    for (int i = 0; i < 40; i++) begin
      run_txn(1'($urandom), 2'($urandom), 3'($urandom), 16'($urandom),
              (($urandom % 3) == 0) ? int'($urandom % 16) : 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule